// File: doc/BRIEF.md
# Edge-Timed Capture Timer

This timer channel measures an external digital input against an internal time base. A 4-bit mode selector picks one of two measurements. In pulse-width mode the counter runs only while the input sits at its active level, and it accumulates across pulses. In input-period mode the counter measures the time between two successive edges of the same direction. When a measurement ends, the running count is copied into a capture register and a sticky completion flag is raised. An interrupt line follows that flag when it is enabled.

The counter advances on an internal tick. The tick is either one pulse every two system clocks or a pulse from an external prescaler. A preload value seeds the counter when a measurement is armed. A reload control selects between restarting from the preload and continuing from the current count. An invert control swaps the edge roles. The input passes through a two-flop synchronizer. A change on the input therefore takes effect on the third rising clock edge after it.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, the counter and capture register are zero, and the completion flag, overflow flag and interrupt output are low.
- R2: With mode selector 0101 (period mode), the first active edge loads the counter from the preload. The next active edge copies the counter into the capture register and sets the completion flag. The captured value is preload plus the number of ticks in between, modulo 2^CNT_W.
- R3: In period mode, the active edge is rising when invert is 0 and falling when invert is 1. Edges of the other direction change neither the count nor the flags.
- R4: In period mode with reload set, each capture also reloads the counter from the preload. Counting continues, and each later active edge captures again.
- R5: In period mode with reload clear, the counter keeps counting from the captured value after the capture. No further captures occur until the timer is disabled and re-armed.
- R6: With mode selector 0100 (pulse-width mode), the leading edge (rising when invert is 0, falling when invert is 1) loads the preload and starts counting. The opposite (trailing) edge stops the counter, copies it into the capture register and sets the completion flag.
- R7: In pulse-width mode with reload clear, the counter holds between a trailing edge and the next leading edge, ignoring ticks. It then resumes from its held value, so the next capture holds the accumulated width.
- R8: In pulse-width mode with reload set, the leading edge after a capture reloads the counter from the preload.
- R9: A tick with the counter at all ones wraps it to zero and sets the overflow flag.
- R10: Both flags are sticky. Each clears only on a one-cycle pulse of its own clear input. The interrupt output is high exactly when the completion flag and the interrupt enable are both high.
- R11: With tick_sel at 0, the counter advances once every two clocks. With tick_sel at 1, it advances once per clock cycle in which prescale_tick is high.
- R12: With enable low, or with a mode selector other than 0100 or 0101, the counter is frozen and ignores edges and ticks. The channel returns to waiting for its first edge, so the next active edge after re-enabling loads the preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | 0100 pulse width, 0101 input period |
| enable | input | 1 | Timer run control |
| reload | input | 1 | Reload-from-preload control |
| invert | input | 1 | Swaps edge polarity |
| tick_sel | input | 1 | 0: clock/2 tick, 1: external prescaler tick |
| prescale_tick | input | 1 | One-cycle tick pulses from a prescaler |
| preload | input | CNT_W | Value loaded when a measurement is armed |
| cmp_irq_en | input | 1 | Interrupt enable for the completion flag |
| cmp_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| sig_in | input | 1 | Asynchronous measured input |
| count | output | CNT_W | Live counter value |
| capture | output | CNT_W | Last captured count |
| cmp_flag | output | 1 | Sticky completion flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong internal state shows up at the ports in one of two ways: as a mistimed counter or as a wrong capture. If the waiting, running, holding or free-running state is wrong, the live count moves or freezes against the ticks. That difference is visible one tick later. If the edge role is wrong, a capture appears on the wrong edge, or the counter reloads when it should resume. The bench sees this at the third clock after the input changes, through the capture value and the completion flag. Sweeps over preload, tick count and invert compare every result with preload plus ticks, modulo 256.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_FREE = 2'd3
  } ect_state_e;

  localparam logic [3:0] MODE_PULSE  = 4'b0100;
  localparam logic [3:0] MODE_PERIOD = 4'b0101;
endpackage

// File: rtl/ect_edge_sync.sv
module ect_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], sig_i};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] & prev_q;

  // R3
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ect_tick.sv
module ect_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic src_i,
  input  logic ext_i,
  output logic tick_o
);
  logic ph_q, ph_d;

  always_comb begin
    ph_d = run_i ? ~ph_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign tick_o = src_i ? ext_i : ph_q;

  // R11
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_i && tick_o) |=> !(tick_o && !src_i));
endmodule

// File: rtl/ect_core.sv
module ect_core
  import ect_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             period_i,
  input  logic             reload_i,
  input  logic             invert_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             cie_i,
  input  logic             cmp_clr_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             cmp_o,
  output logic             ovf_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ect_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             cmp_q, cmp_d;
  logic             ovf_q, ovf_d;
  logic             lead, trail, stop_edge;
  logic             cap_evt, wrap;

  always_comb begin
    lead      = invert_i ? fall_i : rise_i;
    trail     = invert_i ? rise_i : fall_i;
    stop_edge = period_i ? lead : trail;
    state_d   = state_q;
    cnt_d     = cnt_q;
    cap_d     = cap_q;
    cap_evt   = 1'b0;
    wrap      = 1'b0;
    if (!active_i) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (lead) begin
            cnt_d   = preload_i;
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (stop_edge) begin
            cap_evt = 1'b1;
            cap_d   = cnt_q;
            if (period_i) begin
              if (reload_i) cnt_d   = preload_i;
              else          state_d = ST_FREE;
            end else begin
              state_d = reload_i ? ST_WAIT : ST_HOLD;
            end
          end else if (tick_i) begin
            wrap  = &cnt_q;
            cnt_d = cnt_q + ONE;
          end
        end
        ST_HOLD: begin
          if (lead) state_d = ST_RUN;
        end
        ST_FREE: begin
          if (tick_i) begin
            wrap  = &cnt_q;
            cnt_d = cnt_q + ONE;
          end
        end
        default: state_d = ST_WAIT;
      endcase
    end
    cmp_d = cap_evt | (cmp_q & ~cmp_clr_i);
    ovf_d = wrap | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      cap_q   <= '0;
      cmp_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (cap_evt) cap_q <= cap_d;
      cmp_q   <= cmp_d;
      ovf_q   <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign cmp_o = cmp_q;
  assign ovf_o = ovf_q;
  assign irq_o = cmp_q & cie_i;

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt_q)) && cmp_q);

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0) && ovf_q);

  // R12
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (state_q == ST_WAIT) && $stable(cnt_q));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> $stable(cnt_q));
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_sel,
  input  logic             enable,
  input  logic             reload,
  input  logic             invert,
  input  logic             tick_sel,
  input  logic             prescale_tick,
  input  logic [CNT_W-1:0] preload,
  input  logic             cmp_irq_en,
  input  logic             cmp_clr,
  input  logic             ovf_clr,
  input  logic             sig_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             cmp_flag,
  output logic             ovf_flag,
  output logic             irq
);
  logic active, period, rise, fall, tick;

  assign period = (mode_sel == MODE_PERIOD);
  assign active = enable & (period | (mode_sel == MODE_PULSE));

  ect_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sig_i(sig_in), .rise_o(rise), .fall_o(fall)
  );

  ect_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(active), .src_i(tick_sel),
    .ext_i(prescale_tick), .tick_o(tick)
  );

  ect_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .active_i(active), .period_i(period),
    .reload_i(reload), .invert_i(invert), .rise_i(rise), .fall_i(fall),
    .tick_i(tick), .preload_i(preload), .cie_i(cmp_irq_en),
    .cmp_clr_i(cmp_clr), .ovf_clr_i(ovf_clr), .cnt_o(count),
    .cap_o(capture), .cmp_o(cmp_flag), .ovf_o(ovf_flag), .irq_o(irq)
  );
endmodule

// File: tb/edge_capture_timer_tb.sv
module edge_capture_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mode_sel;
  logic       enable, reload, invert, tick_sel, prescale_tick;
  logic [7:0] preload;
  logic       cmp_irq_en, cmp_clr, ovf_clr, sig_in;
  logic [7:0] count, capture;
  logic       cmp_flag, ovf_flag, irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  edge_capture_timer #(.CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .enable(enable),
    .reload(reload), .invert(invert), .tick_sel(tick_sel),
    .prescale_tick(prescale_tick), .preload(preload),
    .cmp_irq_en(cmp_irq_en), .cmp_clr(cmp_clr), .ovf_clr(ovf_clr),
    .sig_in(sig_in), .count(count), .capture(capture),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) prescale_tick = 1'b1;
      @(negedge clk) prescale_tick = 1'b0;
    end
  endtask

  task automatic set_sig(input logic v);
    @(negedge clk) sig_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk) begin cmp_clr = 1'b1; ovf_clr = 1'b1; end
    @(negedge clk) begin cmp_clr = 1'b0; ovf_clr = 1'b0; end
  endtask

  task automatic start(input logic [3:0] m, input logic inv, input logic rl,
                       input logic [7:0] pre);
    @(negedge clk) enable = 1'b0;
    mode_sel = m; invert = inv; reload = rl; preload = pre; tick_sel = 1'b1;
    set_sig(inv);
    clr_flags();
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int exp_v, first;
    rst_n = 1'b0; mode_sel = 4'd0; enable = 1'b0; reload = 1'b0; invert = 1'b0;
    tick_sel = 1'b1; prescale_tick = 1'b0; preload = 8'd0; cmp_irq_en = 1'b0;
    cmp_clr = 1'b0; ovf_clr = 1'b0; sig_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 capture", capture, 0);
    chk("R1 cmp_flag", cmp_flag, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);

    // R2 R3 R9 R10: period sweep
    for (int inv = 0; inv < 2; inv++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int n = 0; n < 12; n += 4) begin
          int pre;
          pre = (pi == 0) ? 0 : (pi == 1) ? 7 : (pi == 2) ? 200 : 250;
          cmp_irq_en = inv[0];
          start(4'b0101, inv[0], 1'b0, pre[7:0]);
          set_sig(!inv[0]);
          chk("R2 arm load", count, pre);
          ticks(n);
          exp_v = (pre + n) % 256;
          set_sig(inv[0]);
          chk("R3 wrong edge count", count, exp_v);
          chk("R3 wrong edge flag", cmp_flag, 0);
          set_sig(!inv[0]);
          chk("R2 capture", capture, exp_v);
          chk("R2 cmp_flag", cmp_flag, 1);
          chk("R9 ovf_flag", ovf_flag, (pre + n > 255) ? 1 : 0);
          chk("R10 irq", irq, inv);
        end
      end
    end

    // R10: sticky and separate clears
    start(4'b0100, 1'b0, 1'b0, 8'd254);
    cmp_irq_en = 1'b1;
    set_sig(1'b1);
    ticks(3);
    chk("R9 wrap count", count, 1);
    chk("R9 ovf set", ovf_flag, 1);
    set_sig(1'b0);
    repeat (5) @(negedge clk);
    chk("R10 cmp sticky", cmp_flag, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R10 ovf cleared", ovf_flag, 0);
    chk("R10 cmp kept", cmp_flag, 1);
    chk("R10 irq high", irq, 1);
    cmp_irq_en = 1'b0;
    @(negedge clk);
    chk("R10 irq masked", irq, 0);
    @(negedge clk) cmp_clr = 1'b1;
    @(negedge clk) cmp_clr = 1'b0;
    chk("R10 cmp cleared", cmp_flag, 0);

    // R4 reload period
    for (int inv = 0; inv < 2; inv++) begin
      start(4'b0101, inv[0], 1'b1, 8'd30);
      set_sig(!inv[0]);
      ticks(5);
      set_sig(inv[0]);
      set_sig(!inv[0]);
      chk("R4 capture", capture, 35);
      chk("R4 reloaded", count, 30);
      clr_flags();
      ticks(9);
      set_sig(inv[0]);
      set_sig(!inv[0]);
      chk("R4 second capture", capture, 39);
      chk("R4 second flag", cmp_flag, 1);
    end

    // R5 free run
    start(4'b0101, 1'b0, 1'b0, 8'd50);
    set_sig(1'b1);
    ticks(6);
    set_sig(1'b0);
    set_sig(1'b1);
    chk("R5 capture", capture, 56);
    chk("R5 count kept", count, 56);
    clr_flags();
    ticks(4);
    chk("R5 keeps counting", count, 60);
    set_sig(1'b0);
    set_sig(1'b1);
    chk("R5 no recapture", capture, 56);
    chk("R5 no flag", cmp_flag, 0);

    // R6 R7 R8 pulse sweep
    for (int inv = 0; inv < 2; inv++) begin
      for (int rl = 0; rl < 2; rl++) begin
        for (int n = 2; n < 8; n += 4) begin
          start(4'b0100, inv[0], rl[0], 8'd100);
          set_sig(!inv[0]);
          chk("R6 lead load", count, 100);
          ticks(n);
          set_sig(inv[0]);
          chk("R6 capture", capture, 100 + n);
          chk("R6 flag", cmp_flag, 1);
          ticks(4);
          chk("R7 held", count, 100 + n);
          set_sig(!inv[0]);
          first = (rl == 1) ? 100 : 100 + n;
          chk(rl ? "R8 reload" : "R7 resume", count, first);
          ticks(3);
          set_sig(inv[0]);
          chk(rl ? "R8 capture" : "R7 accumulated", capture, first + 3);
        end
      end
    end

    // R11 clock/2 source
    start(4'b0101, 1'b0, 1'b0, 8'd0);
    tick_sel = 1'b0;
    set_sig(1'b1);
    exp_v = count;
    repeat (20) @(negedge clk);
    chk("R11 half rate", (count - exp_v) & 8'hff, 10);
    tick_sel = 1'b1;
    exp_v = count;
    repeat (6) @(negedge clk);
    chk("R11 ext idle", count, exp_v);

    // R12 enable low and unsupported mode
    start(4'b0101, 1'b0, 1'b0, 8'd10);
    set_sig(1'b1);
    ticks(2);
    @(negedge clk) enable = 1'b0;
    ticks(3);
    chk("R12 frozen", count, 12);
    @(negedge clk) enable = 1'b1;
    ticks(2);
    chk("R12 waiting", count, 12);
    set_sig(1'b0);
    set_sig(1'b1);
    chk("R12 rearm load", count, 10);
    chk("R12 no capture", cmp_flag, 0);
    @(negedge clk) mode_sel = 4'b0011;
    ticks(3);
    set_sig(1'b0);
    set_sig(1'b1);
    chk("R12 bad mode count", count, 10);
    chk("R12 bad mode flag", cmp_flag, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule